// File: doc/BRIEF.md
# Redundant Link Frame Checker and Selector

This block takes the two copies of a 256-bit acquisition frame that arrive over a primary link (A) and a backup link (B). Each copy is held until its partner arrives or a timeout expires. The block then computes a CRC-32 over the data part of each copy and checks it against that copy's own check field. It also compares the two received check fields with each other.

From these three results, a fixed decision table picks the copy to forward. If no copy can be trusted, the table raises a dump request instead. Any outcome other than the clean one also sets a software-visible error flag.

For the copy it uses, the block checks the card identity against an expected value and checks that the frame counter has advanced by exactly one. It then forwards the 160-bit measurement payload and the 10-bit tunnel status field, with the counter, identity and padding bits removed. A downstream threshold stage uses the payload, and the dump line goes to the beam-permit logic.

Top module: `dual_link_selector`

## Requirements
- R1: Frame layout: card identity in bits [255:240], frame counter in [239:224], payload in [223:64], tunnel status in [63:54], padding in [53:32], check field in [31:0]. A copy fails its check when the CRC-32 over bits 255 down to 32 does not equal its check field. The CRC is computed MSB first, with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, no reflection and no final inversion.
- R2: When both copies fail their check, `out_dump` is set and `out_sel_b` is 0. This holds whether the two check fields are equal or differ.
- R3: When only copy A fails, copy B is selected (`out_sel_b`=1) and there is no dump. This holds whether or not the two check fields agree.
- R4: When only copy B fails, copy A is selected (`out_sel_b`=0) and there is no dump. This holds whether or not the two check fields agree.
- R5: When both copies pass but their check fields differ, `out_dump` is set.
- R6: When both copies pass and their check fields are equal, copy A is selected with no dump, `out_sw_error`=0 and `out_crc_differ`=0. `out_sw_error` is 1 for every other outcome.
- R7: The decision appears as a one-cycle `out_valid` pulse on the clock edge after the edge at which the second copy was captured. The two copies may be captured on different edges.
- R8: If only one copy is held for TMO_CYC edges after its capture edge, a decision is made on that edge. `out_timeout` is set, and the missing copy is reported as having failed its check.
- R9: `out_card_bad` is 1 when the identity field of the copy used differs from `exp_card_id`. The copy used is the selected one, or A on a dump when A is present.
- R10: `out_frame_gap` is 1 when the frame counter of the copy used is not the previous decision's counter plus one, modulo 2^16. The first decision after reset is never flagged.
- R11: `out_payload` carries the payload field of the copy used, and is all zeros on a dump. `out_status` carries that copy's status field in every outcome.
- R12: While reset is active and after its release, before any decision, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Copy A present this cycle |
| a_frame | input | 256 | Copy A frame |
| b_valid | input | 1 | Copy B present this cycle |
| b_frame | input | 256 | Copy B frame |
| exp_card_id | input | 16 | Expected card identity |
| out_valid | output | 1 | Decision pulse |
| out_sel_b | output | 1 | 1 when copy B was selected |
| out_dump | output | 1 | Dump request |
| out_sw_error | output | 1 | Non-default outcome |
| out_crc_fail_a | output | 1 | Copy A failed its check or was missing |
| out_crc_fail_b | output | 1 | Copy B failed its check or was missing |
| out_crc_differ | output | 1 | Received check fields differ |
| out_timeout | output | 1 | Decision forced by timeout |
| out_card_bad | output | 1 | Card identity mismatch |
| out_frame_gap | output | 1 | Frame counter discontinuity |
| out_payload | output | 160 | Selected payload |
| out_status | output | 10 | Selected tunnel status |

## Verification
The hardest rows of the table to reach are the inconsistent ones. In these, both copies carry internally valid check fields that differ, or both copies fail while their check fields are still identical. Reaching them from the ports needs frames whose corruption is placed deliberately, so the bench builds each frame with its own CRC model. It then flips a data bit, or flips a check-field bit, or rebuilds B with a different payload and a fresh CRC. The timeout path is reached by driving only one link and counting edges to the forced decision. A staggered arrival confirms that the decision waits for the later copy.

// File: rtl/dlcs_pkg.sv
package dlcs_pkg;

   typedef struct packed {
      logic sel_b;
      logic dump;
      logic sw_flag;
   } dlcs_pick_t;

   localparam int unsigned LINKS = 2;

endpackage

// File: rtl/dlcs_link_slot.sv
module dlcs_link_slot #(
   parameter int unsigned FRAME_W = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [FRAME_W-1:0] in_frame,
   input  logic               clear,
   output logic               held,
   output logic [FRAME_W-1:0] frame_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held    <= 1'b0;
         frame_q <= '0;
      end else if (clear) begin
         held <= in_valid;
         if (in_valid) frame_q <= in_frame;
      end else if (in_valid && !held) begin
         held    <= 1'b1;
         frame_q <= in_frame;
      end
   end

endmodule

// File: rtl/dlcs_crc_chk.sv
module dlcs_crc_chk #(
   parameter int unsigned          FRAME_W  = 256,
   parameter int unsigned          CRC_W    = 32,
   parameter logic [CRC_W-1:0]     CRC_POLY = 32'h04C11DB7,
   parameter logic [CRC_W-1:0]     CRC_INIT = '1
) (
   input  logic [FRAME_W-1:0] frame,
   output logic               fail
);

   localparam int unsigned DATA_W = FRAME_W - CRC_W;

   function automatic logic [CRC_W-1:0] crc_of(input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = CRC_INIT;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = c[CRC_W-1] ^ d[i];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction

   always_comb begin
      fail = (crc_of(frame[FRAME_W-1:CRC_W]) != frame[CRC_W-1:0]);
   end

endmodule

// File: rtl/dlcs_pick_table.sv
module dlcs_pick_table
   import dlcs_pkg::*;
(
   input  logic       fail_a,
   input  logic       fail_b,
   input  logic       differ,
   output dlcs_pick_t pick
);

   always_comb begin
      pick = '{sel_b: 1'b0, dump: 1'b0, sw_flag: 1'b1};
      unique case ({fail_a, fail_b})
         2'b11: pick.dump  = 1'b1;
         2'b10: pick.sel_b = 1'b1;
         2'b01: pick.sel_b = 1'b0;
         default: begin
            if (differ) pick.dump    = 1'b1;
            else        pick.sw_flag = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/dual_link_selector.sv
module dual_link_selector
   import dlcs_pkg::*;
#(
   parameter int unsigned      FRAME_W  = 256,
   parameter int unsigned      CRC_W    = 32,
   parameter int unsigned      ID_W     = 16,
   parameter int unsigned      PAY_W    = 160,
   parameter int unsigned      STAT_W   = 10,
   parameter int unsigned      TMO_CYC  = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
   parameter logic [CRC_W-1:0] CRC_INIT = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_valid,
   input  logic [FRAME_W-1:0] a_frame,
   input  logic               b_valid,
   input  logic [FRAME_W-1:0] b_frame,
   input  logic [ID_W-1:0]    exp_card_id,
   output logic               out_valid,
   output logic               out_sel_b,
   output logic               out_dump,
   output logic               out_sw_error,
   output logic               out_crc_fail_a,
   output logic               out_crc_fail_b,
   output logic               out_crc_differ,
   output logic               out_timeout,
   output logic               out_card_bad,
   output logic               out_frame_gap,
   output logic [PAY_W-1:0]   out_payload,
   output logic [STAT_W-1:0]  out_status
);

   localparam int unsigned CARD_LSB = FRAME_W - ID_W;
   localparam int unsigned FID_LSB  = CARD_LSB - ID_W;
   localparam int unsigned PAY_LSB  = FID_LSB - PAY_W;
   localparam int unsigned STAT_LSB = PAY_LSB - STAT_W;
   localparam int unsigned TMO_W    = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;

   if (2 * ID_W + PAY_W + STAT_W + CRC_W > FRAME_W) begin : g_bad_layout
      $error("frame fields do not fit in FRAME_W");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("TMO_CYC must be at least 2");
   end

   logic [LINKS-1:0]   link_vld;
   logic [FRAME_W-1:0] link_in  [LINKS];
   logic [FRAME_W-1:0] link_q   [LINKS];
   logic [LINKS-1:0]   held;
   logic [LINKS-1:0]   crc_bad;
   logic               decide;

   assign link_vld   = {b_valid, a_valid};
   assign link_in[0] = a_frame;
   assign link_in[1] = b_frame;

   for (genvar k = 0; k < LINKS; k++) begin : g_link
      dlcs_link_slot #(.FRAME_W(FRAME_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (link_vld[k]),
         .in_frame (link_in[k]),
         .clear    (decide),
         .held     (held[k]),
         .frame_q  (link_q[k])
      );
      dlcs_crc_chk #(
         .FRAME_W  (FRAME_W),
         .CRC_W    (CRC_W),
         .CRC_POLY (CRC_POLY),
         .CRC_INIT (CRC_INIT)
      ) u_crc (
         .frame (link_q[k]),
         .fail  (crc_bad[k])
      );
   end

   logic have_a, have_b;
   assign have_a = held[0];
   assign have_b = held[1];

   logic             both, only_one, tmo_hit;
   logic [TMO_W-1:0] wait_cnt;

   assign both     = have_a & have_b;
   assign only_one = have_a ^ have_b;
   assign tmo_hit  = only_one && (wait_cnt == TMO_W'(TMO_CYC - 1));
   assign decide   = both | tmo_hit;

   always_ff @(posedge clk) begin
      if (!rst_n || decide || !only_one) wait_cnt <= '0;
      else                                wait_cnt <= wait_cnt + 1'b1;
   end

   logic       fail_a, fail_b, differ, src_b;
   dlcs_pick_t pick;

   assign fail_a = crc_bad[0] | !have_a;
   assign fail_b = crc_bad[1] | !have_b;
   assign differ = both && (link_q[0][CRC_W-1:0] != link_q[1][CRC_W-1:0]);

   dlcs_pick_table u_pick (
      .fail_a (fail_a),
      .fail_b (fail_b),
      .differ (differ),
      .pick   (pick)
   );

   logic [FRAME_W-1:0] src;
   logic [ID_W-1:0]    src_fid;
   logic [ID_W-1:0]    last_fid;
   logic               seen_fid;

   assign src_b   = pick.sel_b | !have_a;
   assign src     = src_b ? link_q[1] : link_q[0];
   assign src_fid = src[FID_LSB +: ID_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_sel_b      <= 1'b0;
         out_dump       <= 1'b0;
         out_sw_error   <= 1'b0;
         out_crc_fail_a <= 1'b0;
         out_crc_fail_b <= 1'b0;
         out_crc_differ <= 1'b0;
         out_timeout    <= 1'b0;
         out_card_bad   <= 1'b0;
         out_frame_gap  <= 1'b0;
         out_payload    <= '0;
         out_status     <= '0;
         last_fid       <= '0;
         seen_fid       <= 1'b0;
      end else begin
         out_valid <= decide;
         if (decide) begin
            out_sel_b      <= pick.sel_b;
            out_dump       <= pick.dump;
            out_sw_error   <= pick.sw_flag;
            out_crc_fail_a <= fail_a;
            out_crc_fail_b <= fail_b;
            out_crc_differ <= differ;
            out_timeout    <= tmo_hit;
            out_card_bad   <= (src[CARD_LSB +: ID_W] != exp_card_id);
            out_frame_gap  <= seen_fid && (src_fid != last_fid + 1'b1);
            out_payload    <= pick.dump ? '0 : src[PAY_LSB +: PAY_W];
            out_status     <= src[STAT_LSB +: STAT_W];
            last_fid       <= src_fid;
            seen_fid       <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dual_link_selector_chk.sv
module dual_link_selector_chk #(
   parameter int unsigned PAY_W = 160
) (
   input logic             clk,
   input logic             rst_n,
   input logic             have_a,
   input logic             have_b,
   input logic             out_valid,
   input logic             out_sel_b,
   input logic             out_dump,
   input logic             out_sw_error,
   input logic             out_crc_fail_a,
   input logic             out_crc_fail_b,
   input logic             out_crc_differ,
   input logic             out_timeout,
   input logic [PAY_W-1:0] out_payload
);

   p_decide_after_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (have_a && have_b) |=> out_valid);

   p_dump_flags_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_dump) |-> out_sw_error);

   p_clean_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sw_error) |-> (!out_sel_b && !out_dump && !out_crc_differ
                                         && !out_crc_fail_a && !out_crc_fail_b));

   p_b_only_if_a_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sel_b) |-> (out_crc_fail_a && !out_crc_fail_b && !out_dump));

   p_both_bad_dump_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_crc_fail_a && out_crc_fail_b) |-> out_dump);

   p_dump_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_dump |-> (out_payload == '0));

   p_timeout_missing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_timeout) |-> (out_crc_fail_a || out_crc_fail_b));

endmodule

bind dual_link_selector dual_link_selector_chk #(.PAY_W(PAY_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .have_a         (have_a),
   .have_b         (have_b),
   .out_valid      (out_valid),
   .out_sel_b      (out_sel_b),
   .out_dump       (out_dump),
   .out_sw_error   (out_sw_error),
   .out_crc_fail_a (out_crc_fail_a),
   .out_crc_fail_b (out_crc_fail_b),
   .out_crc_differ (out_crc_differ),
   .out_timeout    (out_timeout),
   .out_payload    (out_payload)
);

// File: tb/dual_link_selector_tb.sv
module dual_link_selector_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TMO        = 16;
   localparam logic [15:0] CARD = 16'h1234;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         a_valid = 1'b0, b_valid = 1'b0;
   logic [255:0] a_frame = '0, b_frame = '0;
   logic [15:0]  exp_card_id = CARD;
   logic         out_valid, out_sel_b, out_dump, out_sw_error;
   logic         out_crc_fail_a, out_crc_fail_b, out_crc_differ, out_timeout;
   logic         out_card_bad, out_frame_gap;
   logic [159:0] out_payload;
   logic [9:0]   out_status;

   int checks = 0;
   int errors = 0;
   logic [15:0] fid = 16'd100;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_link_selector #(.TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_valid(a_valid), .a_frame(a_frame),
      .b_valid(b_valid), .b_frame(b_frame),
      .exp_card_id(exp_card_id),
      .out_valid(out_valid), .out_sel_b(out_sel_b), .out_dump(out_dump),
      .out_sw_error(out_sw_error), .out_crc_fail_a(out_crc_fail_a),
      .out_crc_fail_b(out_crc_fail_b), .out_crc_differ(out_crc_differ),
      .out_timeout(out_timeout), .out_card_bad(out_card_bad),
      .out_frame_gap(out_frame_gap), .out_payload(out_payload),
      .out_status(out_status)
   );

   // R1 reference CRC
   function automatic logic [31:0] ref_crc(input logic [255:0] f);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 255; i >= 32; i--) begin
         logic top = c[31] ^ f[i];
         c = {c[30:0], 1'b0};
         if (top) c = c ^ 32'h04C1_1DB7;
      end
      return c;
   endfunction

   function automatic logic [255:0] build(input logic [15:0] card, input logic [15:0] id,
                                          input logic [159:0] pay, input logic [9:0] st);
      logic [255:0] f = {card, id, pay, st, 22'h0, 32'h0};
      f[31:0] = ref_crc(f);
      return f;
   endfunction

   function automatic logic [159:0] pay_of(input int n);
      return {5{32'hA5C3_0000 + 32'(n)}};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // Drive copies on one edge, then wait for the decision edge.
   task automatic send(input logic va, input logic [255:0] fa,
                       input logic vb, input logic [255:0] fb);
      @(negedge clk);
      a_valid = va; a_frame = fa; b_valid = vb; b_frame = fb;
      @(negedge clk);
      a_valid = 1'b0; b_valid = 1'b0;
      if (va && vb) begin
         @(negedge clk);
      end else begin
         repeat (TMO - 1) @(negedge clk);
         chk("R8 no decision before timeout", 64'(out_valid), 64'd0);
         @(negedge clk);
      end
      chk("R7 decision pulse", 64'(out_valid), 64'd1);
   endtask

   // Vector: {mode_a[1:0], mode_b[1:0], exp_sel_b, exp_dump, exp_sw}
   // mode 0 clean, 1 data bit flipped, 2 check-field bit flipped, 3 other payload, fresh CRC
   localparam logic [6:0] VEC [8] = '{
      {2'd0, 2'd0, 1'b0, 1'b0, 1'b0},  // R6
      {2'd1, 2'd0, 1'b1, 1'b0, 1'b1},  // R3 same CRC fields
      {2'd2, 2'd0, 1'b1, 1'b0, 1'b1},  // R3 differing CRC fields
      {2'd0, 2'd1, 1'b0, 1'b0, 1'b1},  // R4 same
      {2'd0, 2'd2, 1'b0, 1'b0, 1'b1},  // R4 differing
      {2'd1, 2'd1, 1'b0, 1'b1, 1'b1},  // R2 same
      {2'd2, 2'd1, 1'b0, 1'b1, 1'b1},  // R2 differing
      {2'd0, 2'd3, 1'b0, 1'b1, 1'b1}   // R5
   };

   function automatic logic [255:0] apply(input logic [1:0] m, input logic [255:0] f,
                                          input logic [159:0] alt);
      logic [255:0] g = f;
      case (m)
         2'd1: g[100] = ~g[100];
         2'd2: g[5]   = ~g[5];
         2'd3: g = build(f[255:240], f[239:224], alt, f[63:54]);
         default: ;
      endcase
      return g;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [255:0] base, fa, fb, exp_src;
      repeat (3) @(negedge clk);
      chk("R12 valid in reset", 64'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 outputs after reset",
          {out_valid, out_sel_b, out_dump, out_sw_error, out_timeout, out_frame_gap}, 0);
      chk("R12 payload after reset", 64'(out_payload == '0), 1);

      for (int v = 0; v < 8; v++) begin
         base = build(CARD, fid, pay_of(v), 10'(v + 3));
         fa = apply(VEC[v][6:5], base, pay_of(v + 50));
         fb = apply(VEC[v][4:3], base, pay_of(v + 50));
         send(1'b1, fa, 1'b1, fb);
         chk($sformatf("R2-table v%0d sel_b", v), 64'(out_sel_b), 64'(VEC[v][2]));
         chk($sformatf("R5-table v%0d dump", v), 64'(out_dump), 64'(VEC[v][1]));
         chk($sformatf("R6 v%0d sw_error", v), 64'(out_sw_error), 64'(VEC[v][0]));
         exp_src = VEC[v][2] ? fb : fa;
         chk($sformatf("R11 v%0d payload", v), 64'(out_payload ==
             (VEC[v][1] ? 160'h0 : exp_src[223:64])), 1);
         chk($sformatf("R11 v%0d status", v), 64'(out_status), 64'(exp_src[63:54]));
         chk($sformatf("R10 v%0d no gap", v), 64'(out_frame_gap), 0);
         chk($sformatf("R9 v%0d card ok", v), 64'(out_card_bad), 0);
         fid++;
      end

      // R1: a single flipped bit in A's check field alone must be caught
      base = build(CARD, fid, pay_of(20), 10'h2A);
      fa = base; fa[31] = ~fa[31];
      send(1'b1, fa, 1'b1, base);
      chk("R1 fail_a", {out_crc_fail_a, out_crc_fail_b, out_crc_differ}, 64'b101);
      fid++;

      // R8: only A arrives
      base = build(CARD, fid, pay_of(30), 10'h11);
      send(1'b1, base, 1'b0, '0);
      chk("R8 A-only flags", {out_timeout, out_crc_fail_a, out_crc_fail_b, out_sel_b, out_dump,
                              out_sw_error}, 64'b101001);
      chk("R8 A-only payload", 64'(out_payload == pay_of(30)), 1);
      fid++;

      // R8: only B arrives
      base = build(CARD, fid, pay_of(31), 10'h12);
      send(1'b0, '0, 1'b1, base);
      chk("R8 B-only flags", {out_timeout, out_crc_fail_a, out_crc_fail_b, out_sel_b, out_dump},
          64'b11010);
      chk("R8 B-only payload", 64'(out_payload == pay_of(31)), 1);
      fid++;

      // R8 with R2: lone copy is also corrupted
      base = build(CARD, fid, pay_of(32), 10'h13);
      fa = base; fa[150] = ~fa[150];
      send(1'b1, fa, 1'b0, '0);
      chk("R2 lone corrupted copy dumps", {out_timeout, out_dump}, 64'b11);
      fid++;

      // R7: staggered arrival, B two cycles after A
      base = build(CARD, fid, pay_of(40), 10'h21);
      @(negedge clk); a_valid = 1'b1; a_frame = base;
      @(negedge clk); a_valid = 1'b0;
      @(negedge clk); b_valid = 1'b1; b_frame = base;
      @(negedge clk); b_valid = 1'b0;
      chk("R7 not before second copy decided", 64'(out_valid), 0);
      @(negedge clk);
      chk("R7 staggered decision", {out_valid, out_timeout, out_sw_error}, 64'b100);
      fid++;

      // R9: wrong card identity
      base = build(16'hBEEF, fid, pay_of(41), 10'h22);
      send(1'b1, base, 1'b1, base);
      chk("R9 card mismatch", 64'(out_card_bad), 1);
      fid++;

      // R10: skipped frame counter
      fid = fid + 16'd3;
      base = build(CARD, fid, pay_of(42), 10'h23);
      send(1'b1, base, 1'b1, base);
      chk("R10 gap flagged", 64'(out_frame_gap), 1);

      // R10: wrap from FFFF to 0000
      base = build(CARD, 16'hFFFF, pay_of(43), 10'h24);
      send(1'b1, base, 1'b1, base);
      base = build(CARD, 16'h0000, pay_of(44), 10'h25);
      send(1'b1, base, 1'b1, base);
      chk("R10 wrap no gap", 64'(out_frame_gap), 0);

      @(negedge clk);
      chk("R7 pulse one cycle", 64'(out_valid), 0);

      finish_run();
   end

endmodule